// File: doc/BRIEF.md
# Reorder Buffer with Rename Rollback

This block keeps renamed instructions in program order so that they retire in that order and, when one of them faults, the rename map can be put back as it was. Each time the renamer hands over an instruction, the block stores it at the tail of a circular buffer. The stored record holds the architectural destination, the physical tag the destination pointed to before renaming (the displaced tag) and the freshly allocated tag. Execution units later report completion through a write port that names a buffer slot and says whether the instruction faulted.

Completed, fault-free instructions leave from the head one per cycle. Each retirement hands its displaced tag back to the free list. When the head instruction has faulted, the block stops retiring and enters a rollback walk. The walk starts at the youngest entry and moves back to the faulting one, one entry per cycle. For each entry it issues a map-table write that restores the destination to its displaced tag, and it frees the entry's new tag.

At the end of the walk the map reflects only the instructions older than the fault. A single-cycle done pulse marks the last undo. Allocation is refused while the walk runs.

Top module: `rob_rename_rollback`

## Requirements
- R1: After a synchronous active-high reset, the buffer is empty: `occupancy`=0, `alloc_ready`=1, `alloc_idx`=0, and `retire_valid`, `undo_valid`, `free_valid`, `map_wr_valid` and `rollback_busy` are all 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` in the same cycle) writes the record into the slot given by `alloc_idx` in that cycle. Successive allocations use slots that increase by one modulo 8, and each one raises `occupancy` by one.
- R3: With 8 entries held, `alloc_ready` is 0, and an `alloc_valid` in that state is ignored: `occupancy` stays 8 and no extra entry ever retires.
- R4: Completions may arrive in any order. A completed entry does not retire while any older entry is still incomplete.
- R5: Retirement takes the head entry once it is complete and not faulted, at most one entry per cycle, in program order. `retire_valid` is high in the cycle after the clock edge that removes the entry.
- R6: A retiring entry with a destination drives `free_valid`=1 with `free_tag` equal to its displaced tag, never its new tag. A retiring entry without a destination leaves `free_valid` at 0.
- R7: When the head entry is complete and faulted, it does not retire. All older entries have already retired, and the block starts the rollback walk.
- R8: The walk processes one entry per cycle, from the youngest entry down to the faulting entry, and raises `undo_valid` for each. An entry with a destination also drives `map_wr_valid`=1, `map_wr_arch` equal to its destination and `map_wr_tag` equal to its displaced tag.
- R9: An undone entry with a destination drives `free_valid`=1 with `free_tag` equal to its new tag. An undone entry without a destination drives neither `free_valid` nor `map_wr_valid`.
- R10: `rollback_busy` is 1 throughout the walk and `alloc_ready` is 0 whenever `rollback_busy` is 1. `rollback_done` pulses for one cycle together with the undo of the faulting entry, and at that point `occupancy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Renamer offers an instruction |
| alloc_has_dest | input | 1 | Instruction writes a register |
| alloc_arch | input | 4 | Architectural destination |
| alloc_old_tag | input | 6 | Displaced physical tag |
| alloc_new_tag | input | 6 | Newly allocated physical tag |
| alloc_ready | output | 1 | Buffer accepts an allocation this cycle |
| alloc_idx | output | 3 | Slot the offered instruction will occupy |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | 3 | Slot that completed |
| cmpl_fault | input | 1 | Completed instruction faulted |
| retire_valid | output | 1 | One entry retired |
| undo_valid | output | 1 | One entry undone by the walk |
| free_valid | output | 1 | `free_tag` returns to the free list |
| free_tag | output | 6 | Tag being freed |
| map_wr_valid | output | 1 | Map-table restore write |
| map_wr_arch | output | 4 | Register being restored |
| map_wr_tag | output | 6 | Tag it is restored to |
| rollback_busy | output | 1 | Rollback walk in progress |
| rollback_done | output | 1 | Pulse with the last undo |
| occupancy | output | 4 | Number of entries held |

## Verification
The bench sweeps every fill level from one to eight entries and, for each level, every possible faulting position plus a run with no fault. Because earlier runs leave the head at a different slot, the pointers wrap through every slot. Completions arrive youngest-first, so in-order retirement is kept apart from completion order. The split between retire events and undo events shows where the fault boundary falls, and the undo order shows whether the walk runs youngest-first.

The destination flag varies from entry to entry. This tells apart freeing the displaced tag (on retirement) from freeing the new tag (on undo), and shows that entries without a destination free nothing. The full-buffer runs also try an allocation that must be dropped.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ROB_DEPTH = 8;
    localparam int ARCH_W    = 4;
    localparam int PTAG_W    = 6;
    localparam int IDX_W     = $clog2(ROB_DEPTH);
    localparam int CNT_W     = $clog2(ROB_DEPTH + 1);

    typedef struct packed {
        logic              has_dest;
        logic [ARCH_W-1:0] arch;
        logic [PTAG_W-1:0] old_tag;
        logic [PTAG_W-1:0] new_tag;
        logic              done;
        logic              fault;
    } rob_entry_t;

    typedef enum logic {
        WALK_IDLE,
        WALK_ACTIVE
    } walk_state_e;

    function automatic logic [IDX_W-1:0] idx_fwd(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(ROB_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] idx_back(input logic [IDX_W-1:0] p);
        return (p == '0) ? IDX_W'(ROB_DEPTH - 1) : p - 1'b1;
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop_head,
    input  logic             pop_tail,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [IDX_W-1:0] youngest,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (pop_head)
                head <= idx_fwd(head);
            if (push)
                tail <= idx_fwd(tail);
            else if (pop_tail)
                tail <= idx_back(tail);
            count <= count + CNT_W'(push) - CNT_W'(pop_head) - CNT_W'(pop_tail);
        end
    end

    assign youngest = idx_back(tail);
    assign full     = (count == CNT_W'(ROB_DEPTH));

    // R3: never accept an entry into a full buffer
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R5/R8: removal only from a non-empty buffer
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        (pop_head || pop_tail) |-> (count != '0));

    // R8: head and tail removals never overlap
    p_single_pop_r8: assert property (@(posedge clk) disable iff (rst)
        !(pop_head && pop_tail));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(ROB_DEPTH));

endmodule

// File: rtl/rob_slots.sv
module rob_slots
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rob_entry_t       wr_data,
    input  logic             cm_en,
    input  logic [IDX_W-1:0] cm_idx,
    input  logic             cm_fault,
    input  logic [IDX_W-1:0] head_idx,
    input  logic [IDX_W-1:0] young_idx,
    output rob_entry_t       head_ent,
    output rob_entry_t       young_ent
);

    rob_entry_t slot_q [ROB_DEPTH];

    for (genvar g = 0; g < ROB_DEPTH; g++) begin : g_slot
        rob_entry_t ent;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ent <= wr_data;
            end else if (cm_en && cm_idx == IDX_W'(g)) begin
                ent.done  <= 1'b1;
                ent.fault <= cm_fault;
            end
        end
        assign slot_q[g] = ent;
    end

    assign head_ent  = slot_q[head_idx];
    assign young_ent = slot_q[young_idx];

endmodule

// File: rtl/rob_walk.sv
module rob_walk
    import rob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rob_entry_t        head_ent,
    input  rob_entry_t        young_ent,
    input  logic [CNT_W-1:0]  count,
    output logic              pop_head,
    output logic              pop_tail,
    output logic              busy,
    output logic              retire_valid,
    output logic              undo_valid,
    output logic              free_valid,
    output logic [PTAG_W-1:0] free_tag,
    output logic              map_wr_valid,
    output logic [ARCH_W-1:0] map_wr_arch,
    output logic [PTAG_W-1:0] map_wr_tag,
    output logic              done_pulse
);

    walk_state_e state;
    logic        head_ready;
    logic        start_walk;
    logic        last_undo;

    always_comb begin
        head_ready = (state == WALK_IDLE) && (count != '0) && head_ent.done;
        pop_head   = head_ready && !head_ent.fault;
        start_walk = head_ready && head_ent.fault;
        pop_tail   = (state == WALK_ACTIVE);
        last_undo  = pop_tail && (count == CNT_W'(1));
        busy       = (state == WALK_ACTIVE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= WALK_IDLE;
            retire_valid <= 1'b0;
            undo_valid   <= 1'b0;
            free_valid   <= 1'b0;
            free_tag     <= '0;
            map_wr_valid <= 1'b0;
            map_wr_arch  <= '0;
            map_wr_tag   <= '0;
            done_pulse   <= 1'b0;
        end else begin
            if (start_walk)
                state <= WALK_ACTIVE;
            else if (last_undo)
                state <= WALK_IDLE;
            retire_valid <= pop_head;
            undo_valid   <= pop_tail;
            free_valid   <= (pop_head && head_ent.has_dest) ||
                            (pop_tail && young_ent.has_dest);
            free_tag     <= pop_tail ? young_ent.new_tag : head_ent.old_tag;
            map_wr_valid <= pop_tail && young_ent.has_dest;
            map_wr_arch  <= young_ent.arch;
            map_wr_tag   <= young_ent.old_tag;
            done_pulse   <= last_undo;
        end
    end

    // R8: the walk never runs on an empty buffer
    p_walk_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
        (state == WALK_ACTIVE) |-> (count != '0));

    // R8: restore writes only come from undo steps
    p_map_on_undo_r8: assert property (@(posedge clk) disable iff (rst)
        map_wr_valid |-> undo_valid);

    // R5: a cycle is either a retirement or an undo
    p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(retire_valid && undo_valid));

    // R10: the done pulse accompanies an undo and ends the walk
    p_done_with_undo_r10: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (undo_valid && state == WALK_IDLE));

    // R7: a faulted head is never retired
    p_fault_no_retire_r7: assert property (@(posedge clk) disable iff (rst)
        (head_ready && head_ent.fault) |=> !retire_valid);

endmodule

// File: rtl/rob_rename_rollback.sv
module rob_rename_rollback
    import rob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic              alloc_has_dest,
    input  logic [ARCH_W-1:0] alloc_arch,
    input  logic [PTAG_W-1:0] alloc_old_tag,
    input  logic [PTAG_W-1:0] alloc_new_tag,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic              cmpl_fault,
    output logic              retire_valid,
    output logic              undo_valid,
    output logic              free_valid,
    output logic [PTAG_W-1:0] free_tag,
    output logic              map_wr_valid,
    output logic [ARCH_W-1:0] map_wr_arch,
    output logic [PTAG_W-1:0] map_wr_tag,
    output logic              rollback_busy,
    output logic              rollback_done,
    output logic [CNT_W-1:0]  occupancy
);

    logic             push;
    logic             pop_head;
    logic             pop_tail;
    logic             full;
    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic [IDX_W-1:0] youngest;
    rob_entry_t       new_ent;
    rob_entry_t       head_ent;
    rob_entry_t       young_ent;

    always_comb begin
        alloc_ready      = !full && !rollback_busy;
        push             = alloc_valid && alloc_ready;
        alloc_idx        = tail;
        new_ent          = '0;
        new_ent.has_dest = alloc_has_dest;
        new_ent.arch     = alloc_arch;
        new_ent.old_tag  = alloc_old_tag;
        new_ent.new_tag  = alloc_new_tag;
    end

    rob_ptrs u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop_head (pop_head),
        .pop_tail (pop_tail),
        .head     (head),
        .tail     (tail),
        .youngest (youngest),
        .count    (occupancy),
        .full     (full)
    );

    rob_slots u_slots (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (push),
        .wr_idx    (tail),
        .wr_data   (new_ent),
        .cm_en     (cmpl_valid),
        .cm_idx    (cmpl_idx),
        .cm_fault  (cmpl_fault),
        .head_idx  (head),
        .young_idx (youngest),
        .head_ent  (head_ent),
        .young_ent (young_ent)
    );

    rob_walk u_walk (
        .clk          (clk),
        .rst          (rst),
        .head_ent     (head_ent),
        .young_ent    (young_ent),
        .count        (occupancy),
        .pop_head     (pop_head),
        .pop_tail     (pop_tail),
        .busy         (rollback_busy),
        .retire_valid (retire_valid),
        .undo_valid   (undo_valid),
        .free_valid   (free_valid),
        .free_tag     (free_tag),
        .map_wr_valid (map_wr_valid),
        .map_wr_arch  (map_wr_arch),
        .map_wr_tag   (map_wr_tag),
        .done_pulse   (rollback_done)
    );

    // R10: the walk leaves the buffer empty
    p_done_empty_r10: assert property (@(posedge clk) disable iff (rst)
        rollback_done |-> (occupancy == '0));

    // R6: a free on retirement needs a retirement
    p_free_has_source_r6: assert property (@(posedge clk) disable iff (rst)
        free_valid |-> (retire_valid || undo_valid));

endmodule

// File: tb/sim_rob_rename_rollback.sv
module sim_rob_rename_rollback;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alloc_valid = 1'b0;
    logic       alloc_has_dest = 1'b0;
    logic [3:0] alloc_arch = '0;
    logic [5:0] alloc_old_tag = '0;
    logic [5:0] alloc_new_tag = '0;
    logic       alloc_ready;
    logic [2:0] alloc_idx;
    logic       cmpl_valid = 1'b0;
    logic [2:0] cmpl_idx = '0;
    logic       cmpl_fault = 1'b0;
    logic       retire_valid, undo_valid, free_valid, map_wr_valid;
    logic [5:0] free_tag, map_wr_tag;
    logic [3:0] map_wr_arch;
    logic       rollback_busy, rollback_done;
    logic [3:0] occupancy;

    always #10 clk = ~clk;

    rob_rename_rollback u0 (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_has_dest(alloc_has_dest),
        .alloc_arch(alloc_arch), .alloc_old_tag(alloc_old_tag),
        .alloc_new_tag(alloc_new_tag), .alloc_ready(alloc_ready),
        .alloc_idx(alloc_idx), .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
        .cmpl_fault(cmpl_fault), .retire_valid(retire_valid),
        .undo_valid(undo_valid), .free_valid(free_valid), .free_tag(free_tag),
        .map_wr_valid(map_wr_valid), .map_wr_arch(map_wr_arch),
        .map_wr_tag(map_wr_tag), .rollback_busy(rollback_busy),
        .rollback_done(rollback_done), .occupancy(occupancy)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int busy_ready_viol = 0;
    bit finished = 0;

    int ev_kind[$];
    int ev_fv[$];
    int ev_ft[$];
    int ev_mv[$];
    int ev_ma[$];
    int ev_mt[$];
    int ev_dn[$];

    int e_hd[8];
    int e_ar[8];
    int e_old[8];
    int e_new[8];
    int base = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (retire_valid || undo_valid) begin
                ev_kind.push_back(undo_valid ? 1 : 0);
                ev_fv.push_back(int'(free_valid));
                ev_ft.push_back(int'(free_tag));
                ev_mv.push_back(int'(map_wr_valid));
                ev_ma.push_back(int'(map_wr_arch));
                ev_mt.push_back(int'(map_wr_tag));
                ev_dn.push_back(int'(rollback_done));
            end
            if (rollback_busy && alloc_ready)
                busy_ready_viol++;
        end
    end

    task automatic scenario(input int n, input int f);
        int seed;
        int nret;
        int nund;
        seed = n * 8 + f;
        ev_kind.delete(); ev_fv.delete(); ev_ft.delete(); ev_mv.delete();
        ev_ma.delete(); ev_mt.delete(); ev_dn.delete();
        for (int i = 0; i < n; i++) begin
            e_ar[i]  = (seed * 3 + i) % 16;
            e_old[i] = (seed + i * 5) % 32;
            e_new[i] = 32 + ((seed + i * 3) % 32);
            e_hd[i]  = (((seed + i) % 4) != 0) ? 1 : 0;
            alloc_valid    = 1'b1;
            alloc_has_dest = e_hd[i][0];
            alloc_arch     = 4'(e_ar[i]);
            alloc_old_tag  = 6'(e_old[i]);
            alloc_new_tag  = 6'(e_new[i]);
            chk(alloc_ready == 1'b1, "R2 ready", int'(alloc_ready), 1);
            chk(int'(alloc_idx) == (base + i) % 8, "R2 idx", int'(alloc_idx), (base + i) % 8);
            @(negedge clk);
            alloc_valid = 1'b0;
        end
        chk(int'(occupancy) == n, "R2 occupancy", int'(occupancy), n);
        if (n == 8) begin
            chk(alloc_ready == 1'b0, "R3 full ready", int'(alloc_ready), 0);
            alloc_valid   = 1'b1;
            alloc_arch    = 4'hF;
            alloc_old_tag = 6'h3F;
            @(negedge clk);
            alloc_valid = 1'b0;
            chk(int'(occupancy) == 8, "R3 ignored alloc", int'(occupancy), 8);
        end
        for (int i = n - 1; i >= 0; i--) begin
            if (i == 0)
                chk(ev_kind.size() == 0, "R4 no early retire", ev_kind.size(), 0);
            cmpl_valid = 1'b1;
            cmpl_idx   = 3'((base + i) % 8);
            cmpl_fault = (i == f);
            @(negedge clk);
            cmpl_valid = 1'b0;
            cmpl_fault = 1'b0;
        end
        for (int w = 0; w < 40; w++) begin
            if (occupancy == 0 && !rollback_busy) break;
            @(negedge clk);
        end
        @(negedge clk);
        nret = 0;
        nund = 0;
        foreach (ev_kind[k]) begin
            if (ev_kind[k] == 0) nret++;
            else nund++;
        end
        chk(nret == f, "R5 retire count", nret, f);
        chk(nund == n - f, "R8 undo count", nund, n - f);
        chk(int'(occupancy) == 0, "R10 empty after", int'(occupancy), 0);
        if (nret == f && nund == n - f) begin
            for (int k = 0; k < f; k++) begin
                chk(ev_kind[k] == 0, "R7 older retire first", ev_kind[k], 0);
                chk(ev_fv[k] == e_hd[k], "R6 free flag", ev_fv[k], e_hd[k]);
                if (e_hd[k] != 0)
                    chk(ev_ft[k] == e_old[k], "R6 free old tag", ev_ft[k], e_old[k]);
                chk(ev_mv[k] == 0, "R5 no map on retire", ev_mv[k], 0);
            end
            for (int j = 0; j < n - f; j++) begin
                int i = n - 1 - j;
                int k = f + j;
                chk(ev_mv[k] == e_hd[i], "R8 map flag", ev_mv[k], e_hd[i]);
                chk(ev_fv[k] == e_hd[i], "R9 free flag", ev_fv[k], e_hd[i]);
                if (e_hd[i] != 0) begin
                    chk(ev_ma[k] == e_ar[i], "R8 map arch", ev_ma[k], e_ar[i]);
                    chk(ev_mt[k] == e_old[i], "R8 map tag", ev_mt[k], e_old[i]);
                    chk(ev_ft[k] == e_new[i], "R9 free new tag", ev_ft[k], e_new[i]);
                end
                chk(ev_dn[k] == ((j == n - f - 1) ? 1 : 0), "R10 done pulse",
                    ev_dn[k], (j == n - f - 1) ? 1 : 0);
            end
        end
        base = (base + f) % 8;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(int'(occupancy) == 0, "R1 occupancy", int'(occupancy), 0);
        chk(alloc_ready == 1'b1, "R1 ready", int'(alloc_ready), 1);
        chk(int'(alloc_idx) == 0, "R1 idx", int'(alloc_idx), 0);
        chk({retire_valid, undo_valid, free_valid, map_wr_valid, rollback_busy, rollback_done} == '0,
            "R1 idle outputs",
            int'({retire_valid, undo_valid, free_valid, map_wr_valid, rollback_busy, rollback_done}), 0);
        for (int n = 1; n <= 8; n++)
            for (int f = 0; f <= n; f++)
                scenario(n, f);
        chk(busy_ready_viol == 0, "R10 ready low while busy", busy_ready_viol, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule